// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block is the bypass-select logic of a five-stage, in-order integer pipeline. Each cycle it compares the two source register numbers of the instruction in the execute stage with the destination registers held in the two later pipeline registers. The later register after execute is called the memory stage here, and the last one is called the writeback stage. From these matches it produces a select code for each ALU operand mux, so a dependent instruction can read a result that is still in flight.

It also drives a one-bit select for the store-data path in the memory stage. A store whose data register was just loaded can then take the loaded value from the writeback stage. The block also raises a load-use flag when the execute-stage ALU needs a value that a load in the memory stage has not yet fetched. The stall logic consumes that flag.

There is no bypass from any stage older than writeback. The register file writes in the first half of the cycle and is read in the second half, so an instruction in decode already sees a value that is being written back in the same cycle. The whole block is combinational.

Top module: `fwd_unit`

## Requirements
- R1: An execute-stage operand whose register number equals the memory-stage destination gets select code 2'b10. This holds only when the memory-stage write enable is high and the destination is not register 0.
- R2: An operand gets code 2'b01 when it matches a writing, non-zero writeback-stage destination and does not qualify for the memory stage.
- R3: When both later stages qualify for the same operand, the memory stage (the younger result) wins and the code is 2'b10.
- R4: Register 0 is hardwired to zero, so a write aimed at it is never forwarded. A source of register 0 always gets code 2'b00, and the store-data select stays 0.
- R5: A stage whose register write enable is low is never a bypass source, even when its destination matches.
- R6: An operand matching neither qualifying stage gets code 2'b00, which selects the register file.
- R7: load_use_stall is 1 when the memory stage holds a writing load with a non-zero destination that matches operand A. It is also 1 when that destination matches operand B and the execute instruction is not a store.
- R8: When the execute instruction is a store and operand B (its data register) matches a load in the memory stage, no stall is raised for B. Operand B then takes code 2'b01 if the writeback stage qualifies, or 2'b00 otherwise.
- R9: st_data_sel is 1 when the memory stage holds a store whose data register equals a writing, non-zero writeback destination. Otherwise it is 0.
- R10: Each operand select is always one of 2'b00, 2'b01 or 2'b10, and never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_a | input | REG_W | Execute-stage first source register |
| ex_rs_b | input | REG_W | Execute-stage second source register (store data for stores) |
| ex_is_store | input | 1 | Execute-stage instruction is a store |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage register write enable |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_src | input | REG_W | Memory-stage store data register |
| wb_rd | input | REG_W | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage register write enable |
| fwd_a_sel | output | 2 | Operand A select: 00 reg file, 10 memory stage, 01 writeback |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| st_data_sel | output | 1 | 1 selects writeback result as store data |
| load_use_stall | output | 1 | Load-use hazard flag to the stall logic |

## Verification
The hardest case to reach is a store in execute whose data register matches a load in the memory stage, while the writeback stage either matches the same register or does not. Only this combination shows the memory stage being skipped for operand B without a stall. Directed steps set up these exact register overlaps with and without a writeback match. They also cover the pairing that differs only by the store flag, where a stall must appear. After that, random cycles draw register numbers from a small set that includes zero. This makes double matches and zero-register targets frequent, and every cycle is compared with a behavioural model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WB  = 2'b01,
      SEL_MEM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int REG_W    = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);
   logic dst_live;

   generate
      if (ZERO_REG) begin : g_zero
         assign dst_live = |dst;
      end else begin : g_nozero
         assign dst_live = 1'b1;
      end
   endgenerate

   assign hit = wen & dst_live & (src == dst);

   always_comb begin
      if (hit && ZERO_REG) begin
         p_hit_not_zero_r4: assert (dst != '0);
      end
   end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             skip_mem,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       sel,
   output logic             mem_hit
);
   logic wb_hit;
   fwd_sel_e sel_e;

   fwd_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_mem (
      .src(src), .dst(mem_rd), .wen(mem_wen), .hit(mem_hit));
   fwd_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_wb (
      .src(src), .dst(wb_rd), .wen(wb_wen), .hit(wb_hit));

   always_comb begin
      if (mem_hit && !skip_mem) sel_e = SEL_MEM;
      else if (wb_hit)          sel_e = SEL_WB;
      else                      sel_e = SEL_RF;
   end
   assign sel = sel_e;

   always_comb begin
      p_sel_legal_r10: assert (sel != 2'b11);
      if (sel == SEL_MEM) begin
         p_mem_src_r1: assert (mem_wen && (src == mem_rd));
      end
      if (sel == SEL_WB) begin
         p_wb_src_r2: assert (wb_wen && (src == wb_rd));
      end
      if (!mem_wen && !wb_wen) begin
         p_no_wen_r5: assert (sel == SEL_RF);
      end
      if (ZERO_REG && (src == '0)) begin
         p_zero_src_r4: assert (sel == SEL_RF);
      end
   end
endmodule

// File: rtl/fwd_store_data.sv
module fwd_store_data #(
   parameter int REG_W    = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic             mem_is_store,
   input  logic [REG_W-1:0] mem_st_src,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic             st_sel
);
   fwd_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_st (
      .src(mem_st_src), .dst(wb_rd), .wen(wb_wen & mem_is_store), .hit(st_sel));

   always_comb begin
      if (st_sel) begin
         p_st_needs_store_r9: assert (mem_is_store && wb_wen && (wb_rd == mem_st_src));
      end
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int  NUM_REGS = 32,
   parameter bit  ZERO_REG = 1'b1,
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic [REG_W-1:0] ex_rs_a,
   input  logic [REG_W-1:0] ex_rs_b,
   input  logic             ex_is_store,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_is_load,
   input  logic             mem_is_store,
   input  logic [REG_W-1:0] mem_st_src,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             st_data_sel,
   output logic             load_use_stall
);
   generate
      if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_cfg
         $error("fwd_unit: NUM_REGS must be a power of two of at least 2");
      end
   endgenerate

   logic [1:0] hit_mem;
   logic [1:0] skip_mem;
   logic [1:0] sel_q [2];
   logic [REG_W-1:0] srcs [2];

   assign srcs[0]     = ex_rs_a;
   assign srcs[1]     = ex_rs_b;
   assign skip_mem[0] = 1'b0;
   assign skip_mem[1] = ex_is_store & mem_is_load;

   for (genvar i = 0; i < 2; i++) begin : g_op
      fwd_operand_sel #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_sel (
         .src(srcs[i]), .mem_rd(mem_rd), .mem_wen(mem_wen),
         .skip_mem(skip_mem[i]), .wb_rd(wb_rd), .wb_wen(wb_wen),
         .sel(sel_q[i]), .mem_hit(hit_mem[i]));
   end

   assign fwd_a_sel = sel_q[0];
   assign fwd_b_sel = sel_q[1];

   assign load_use_stall = mem_is_load & (hit_mem[0] | (hit_mem[1] & ~ex_is_store));

   fwd_store_data #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_st (
      .mem_is_store(mem_is_store), .mem_st_src(mem_st_src),
      .wb_rd(wb_rd), .wb_wen(wb_wen), .st_sel(st_data_sel));

   always_comb begin
      if (load_use_stall) begin
         p_stall_needs_load_r7: assert (mem_is_load && mem_wen);
      end
      if (ex_is_store && mem_is_load && (ex_rs_b == mem_rd) && (ex_rs_a != mem_rd)) begin
         p_store_data_no_stall_r8: assert (!load_use_stall && fwd_b_sel != SEL_MEM);
      end
      if (fwd_a_sel == SEL_MEM && fwd_b_sel == SEL_MEM) begin
         p_same_src_r3: assert (ex_rs_a == ex_rs_b);
      end
   end
endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
   localparam int RW = 5;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [RW-1:0] ex_rs_a, ex_rs_b, mem_rd, mem_st_src, wb_rd;
   logic ex_is_store, mem_wen, mem_is_load, mem_is_store, wb_wen;
   logic [1:0] fwd_a_sel, fwd_b_sel;
   logic st_data_sel, load_use_stall;
   int n_chk = 0, n_fail = 0;

   fwd_unit u0 (.*);

   function automatic logic [1:0] m_sel(logic [RW-1:0] s, bit is_b);
      bit mh, wh;
      mh = mem_wen && mem_rd != 0 && mem_rd == s && !(is_b && ex_is_store && mem_is_load);
      wh = wb_wen && wb_rd != 0 && wb_rd == s;
      return mh ? 2'b10 : (wh ? 2'b01 : 2'b00);
   endfunction

   function automatic string m_tag(logic [RW-1:0] s, bit is_b);
      bit mq, wq;
      if (s == 0) return "R4";
      mq = mem_wen && mem_rd == s;
      wq = wb_wen && wb_rd == s;
      if (is_b && ex_is_store && mem_is_load && mq) return "R8";
      if (mq && wq) return "R3";
      if (mq) return "R1";
      if (wq) return "R2";
      if (mem_rd == s || wb_rd == s) return "R5";
      return "R6";
   endfunction

   task automatic chk(string req, logic [1:0] act, logic [1:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      bit stall_e, st_e;
      stall_e = mem_is_load && mem_wen && mem_rd != 0 &&
                (mem_rd == ex_rs_a || (mem_rd == ex_rs_b && !ex_is_store));
      st_e = mem_is_store && wb_wen && wb_rd != 0 && wb_rd == mem_st_src;
      chk(m_tag(ex_rs_a, 1'b0), fwd_a_sel, m_sel(ex_rs_a, 1'b0), "sel_a");
      chk(m_tag(ex_rs_b, 1'b1), fwd_b_sel, m_sel(ex_rs_b, 1'b1), "sel_b");
      chk((ex_is_store && mem_rd == ex_rs_b) ? "R8" : "R7", {1'b0, load_use_stall}, {1'b0, stall_e}, "stall");
      chk(mem_st_src == 0 ? "R4" : "R9", {1'b0, st_data_sel}, {1'b0, st_e}, "st_sel");
      chk("R10", {1'b0, fwd_a_sel == 2'b11 || fwd_b_sel == 2'b11}, 2'b00, "illegal code");
   endtask

   task automatic drive(int a, int b, bit est, int mrd, bit mw, bit ml, bit ms, int msrc, int wrd, bit ww);
      @(negedge clk);
      ex_rs_a = RW'(a); ex_rs_b = RW'(b); ex_is_store = est;
      mem_rd = RW'(mrd); mem_wen = mw; mem_is_load = ml; mem_is_store = ms;
      mem_st_src = RW'(msrc); wb_rd = RW'(wrd); wb_wen = ww;
      @(posedge clk); #1;
      check_all();
   endtask

   initial begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      rst = 1'b0;
      chk("R6", fwd_a_sel, 2'b00, "idle sel_a");
      chk("R6", fwd_b_sel, 2'b00, "idle sel_b");
      drive(3, 4, 0, 3, 1, 0, 0, 0, 9, 1);       // R1 operand A from memory stage
      drive(5, 7, 0, 9, 1, 0, 0, 0, 7, 1);       // R2 operand B from writeback
      drive(6, 6, 0, 6, 1, 0, 0, 0, 6, 1);       // R3 both stages, memory wins
      drive(0, 0, 0, 0, 1, 0, 1, 0, 0, 1);       // R4 register zero never forwarded
      drive(8, 8, 0, 8, 0, 0, 1, 8, 8, 0);       // R5 write enables low
      drive(1, 2, 0, 3, 1, 0, 0, 0, 4, 1);       // R6 no match
      drive(10, 2, 0, 10, 1, 1, 0, 0, 0, 0);     // R7 load-use on A
      drive(2, 11, 0, 11, 1, 1, 0, 0, 0, 0);     // R7 load-use on B, not a store
      drive(2, 11, 1, 11, 1, 1, 0, 0, 0, 0);     // R8 store data, no writeback match
      drive(2, 11, 1, 11, 1, 1, 0, 0, 11, 1);    // R8 store data, writeback matches
      drive(11, 11, 1, 11, 1, 1, 0, 0, 11, 1);   // R7 store base address still stalls
      drive(1, 2, 0, 0, 0, 0, 1, 12, 12, 1);     // R9 store data from writeback
      drive(1, 2, 0, 0, 0, 0, 0, 12, 12, 1);     // R9 not a store
      for (int i = 0; i < 3000; i++) begin
         drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
               $urandom_range(0, 3), 1'($urandom), 1'($urandom), 1'($urandom),
               $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom));
      end
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule